// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Cache

This block sits between a network transmit or receive engine and a circular ring of fixed-size descriptors held in host memory. Software programs the ring's base address, its size in bytes and its head and tail indices through a small register port. The block tracks a fetch pointer that marks how far into the ring it has already read. Whenever the ring holds descriptors it has not fetched yet and its local store has room, it issues one burst read. The returned descriptors land in a local circular store, from which the engine takes them one at a time, strictly in ring order.

When the engine takes a descriptor it hands back the completed version, which the store keeps as a used entry. A flush request, carrying an alignment mask, starts a burst write that returns used entries to the ring at the head position. When the write completes, those entries leave the store and the head index moves forward. Only one read burst and one write burst are ever outstanding. A write burst is cut at the end of the ring and is otherwise rounded down to the alignment mask. A flush that asks for a finer alignment while a write is in flight is remembered and is started automatically once that write completes.

Top module: `desc_ring_cache`

## Requirements
- R1: After reset, no request is pending, the error flag is low, head and fetch pointer are 0 and the engine sees no descriptor. The ring size in entries is the byte-length register shifted right by 4 (16-byte entries).
- R2: A read burst covers tail minus fetch pointer entries when tail is at or ahead of the pointer, and ring size minus pointer otherwise, so that it never crosses the ring end.
- R3: The read count is capped at the free store slots (capacity minus used minus unused entries). A count of zero issues no read.
- R4: While a read is outstanding no other read is issued. When its last beat arrives, the fetch pointer advances by the count and wraps to 0 when it reaches the ring size.
- R5: A read is addressed at base + fetch pointer × 16. A write is addressed at base + head × 16.
- R6: A flush writes back the used entries. If head plus that number reaches the ring size, the count becomes ring size minus head and a follow-up write is queued. Otherwise a nonzero mask clears the masked bits of the count.
- R7: A flush that arrives while a write is outstanding issues nothing. If its mask is smaller than the recorded mask, the smaller mask is kept and a follow-up write is queued. A larger or equal mask has no effect.
- R8: When a write completes, its entries leave the store and the head advances by the count, wrapping at the ring size. A queued follow-up write then starts with the recorded mask.
- R9: avail_cnt equals the unused entries plus the distance from the fetch pointer to tail. When the pointer is at or past tail, that distance is taken through the ring end (ring size − pointer + tail).
- R10: A write to base (cfg_sel 0), length (cfg_sel 1) or head (cfg_sel 2) is legal when there are no used entries and no read or write outstanding. It then takes effect, empties the store and sets the fetch pointer to 0. A write to tail (cfg_sel 3) is always accepted.
- R11: An illegal write to base, length or head leaves the register unchanged and sets cfg_err, which stays set until reset.
- R12: The engine receives unused descriptors in ring order. eng_valid is high whenever an unused entry exists, and a write burst exposes the returned results, oldest first, on wb_rd_data indexed by wb_rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 byte length, 2 head, 3 tail |
| cfg_wdata | input | ADDR_W | Register write value |
| cfg_err | output | 1 | Sticky flag for an illegal ring change |
| ring_head | output | IDX_W | Current head index |
| fetch_ptr | output | IDX_W | Current fetch pointer |
| avail_cnt | output | IDX_W+1 | Descriptors still available to the engine |
| rd_req | output | 1 | One-cycle burst read request |
| rd_addr | output | ADDR_W | Burst read byte address |
| rd_cnt | output | CNT_W | Descriptors in the read burst |
| rd_beat_valid | input | 1 | One fetched descriptor is present |
| rd_beat_data | input | DESC_W | Fetched descriptor |
| wb_req | output | 1 | One-cycle burst write request |
| wb_addr | output | ADDR_W | Burst write byte address |
| wb_cnt | output | CNT_W | Descriptors in the write burst |
| wb_rd_idx | input | CAP_W | Offset into the burst being written |
| wb_rd_data | output | DESC_W | Result descriptor at that offset |
| wb_done | input | 1 | Write burst completion pulse |
| eng_valid | output | 1 | An unused descriptor is available |
| eng_desc | output | DESC_W | Oldest unused descriptor |
| eng_take | input | 1 | Engine consumes eng_desc |
| eng_result | input | DESC_W | Completed descriptor returned with eng_take |
| flush_req | input | 1 | Request a writeback |
| flush_mask | input | IDX_W | Alignment mask for the writeback |

## Verification
The assertions assume a well-behaved memory side and engine. The memory side delivers exactly rd_cnt beats, and only while a read is outstanding. It pulses wb_done only for an issued write. The engine pulses eng_take only while eng_valid is high. Software keeps tail and head inside the ring. The bench keeps to these rules by construction. A monitor records every request, and one task per scenario answers the recorded request with exactly the requested beats or a single completion. Takes are driven only after eng_valid has been checked, and tail values stay below the programmed ring size.

// File: rtl/drc_pkg.sv
package drc_pkg;
   // register select codes of the configuration port
   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_LEN  = 2'd1,
      SEL_HEAD = 2'd2,
      SEL_TAIL = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/drc_store.sv
// Local circular descriptor store: [retire, consume) used, [consume, write) unused.
module drc_store #(
   parameter int DESC_W = 128,
   parameter int CAP    = 8,
   localparam int CAP_W = $clog2(CAP),
   localparam int CNT_W = CAP_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [DESC_W-1:0] push_data,
   input  logic              take,
   input  logic [DESC_W-1:0] take_data,
   input  logic              retire,
   input  logic [CNT_W-1:0]  retire_n,
   input  logic [CAP_W-1:0]  peek_idx,
   output logic [DESC_W-1:0] front_data,
   output logic [DESC_W-1:0] peek_data,
   output logic [CNT_W-1:0]  n_used,
   output logic [CNT_W-1:0]  n_unused,
   output logic [CNT_W-1:0]  n_free
);
   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

   logic [CAP_W:0] wr_p, cn_p, rt_p;
   logic [CAP-1:0][DESC_W-1:0] slot_v;
   logic [CAP_W-1:0] peek_pos;

   for (genvar g = 0; g < CAP; g++) begin : g_slot
      logic [DESC_W-1:0] q;
      always_ff @(posedge clk) begin
         if (push && wr_p[CAP_W-1:0] == CAP_W'(g))
            q <= push_data;
         else if (take && cn_p[CAP_W-1:0] == CAP_W'(g))
            q <= take_data;
      end
      assign slot_v[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p <= '0;
         cn_p <= '0;
         rt_p <= '0;
      end else if (clear) begin
         wr_p <= '0;
         cn_p <= '0;
         rt_p <= '0;
      end else begin
         if (push)   wr_p <= wr_p + 1'b1;
         if (take)   cn_p <= cn_p + 1'b1;
         if (retire) rt_p <= rt_p + retire_n;
      end
   end

   assign peek_pos   = rt_p[CAP_W-1:0] + peek_idx;
   assign front_data = slot_v[cn_p[CAP_W-1:0]];
   assign peek_data  = slot_v[peek_pos];
   assign n_used     = cn_p - rt_p;
   assign n_unused   = wr_p - cn_p;
   assign n_free     = CAP_V - (wr_p - rt_p);
endmodule

// File: rtl/drc_fetch.sv
// Burst read control: one read in flight, bursts never cross the ring end.
module drc_fetch #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 12,
   parameter int CNT_W  = 4,
   parameter int DSH    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              hold,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  ring_len,
   input  logic [IDX_W-1:0]  tail,
   input  logic [CNT_W-1:0]  n_free,
   input  logic              beat_valid,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic              busy,
   output logic [IDX_W-1:0]  cptr
);
   logic [IDX_W-1:0] span, free_i, grant;
   logic [CNT_W-1:0] left_q;
   logic [IDX_W:0]   nxt;
   logic             go, last;

   always_comb begin
      span   = (tail >= cptr) ? (tail - cptr) : (ring_len - cptr);
      free_i = IDX_W'(n_free);
      grant  = (span < free_i) ? span : free_i;
      go     = !busy && !hold && (grant != '0);
      last   = busy && beat_valid && (left_q == CNT_W'(1));
      nxt    = {1'b0, cptr} + (IDX_W+1)'(rd_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req  <= 1'b0;
         rd_addr <= '0;
         rd_cnt  <= '0;
         busy    <= 1'b0;
         left_q  <= '0;
         cptr    <= '0;
      end else begin
         rd_req <= go;
         if (go) begin
            busy    <= 1'b1;
            rd_addr <= base + (ADDR_W'(cptr) << DSH);
            rd_cnt  <= CNT_W'(grant);
            left_q  <= CNT_W'(grant);
         end else if (busy && beat_valid) begin
            left_q <= left_q - 1'b1;
         end
         if (clear) begin
            cptr <= '0;
         end else if (last) begin
            busy <= 1'b0;
            cptr <= (nxt == {1'b0, ring_len}) ? '0 : nxt[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/drc_wback.sv
// Burst write control: clipping, alignment, chained follow-up writes, head update.
module drc_wback #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 12,
   parameter int CNT_W  = 4,
   parameter int DSH    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_wr,
   input  logic [IDX_W-1:0]  head_wdata,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  ring_len,
   input  logic [CNT_W-1:0]  n_used,
   input  logic              flush_req,
   input  logic [IDX_W-1:0]  flush_mask,
   input  logic              wb_done,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [CNT_W-1:0]  wb_cnt,
   output logic              busy,
   output logic [IDX_W-1:0]  head,
   output logic              retire,
   output logic [CNT_W-1:0]  retire_n
);
   logic             busy_q, more_q, chain_q;
   logic [IDX_W-1:0] mask_q, eff_mask, used_i, cnt_calc;
   logic [IDX_W:0]   sum, nh, nh_wrap;
   logic             pend_min, trigger, clip;

   always_comb begin
      pend_min = flush_req && (flush_mask < mask_q);
      eff_mask = (chain_q && !pend_min) ? mask_q : flush_mask;
      trigger  = !busy_q && (flush_req || chain_q);
      used_i   = IDX_W'(n_used);
      sum      = {1'b0, head} + {1'b0, used_i};
      clip     = sum >= {1'b0, ring_len};
      if (clip)                 cnt_calc = ring_len - head;
      else if (eff_mask != '0)  cnt_calc = used_i & ~eff_mask;
      else                      cnt_calc = used_i;
      nh       = {1'b0, head} + (IDX_W+1)'(wb_cnt);
      nh_wrap  = nh - {1'b0, ring_len};
   end

   assign retire   = wb_done && busy_q;
   assign retire_n = wb_cnt;
   assign busy     = busy_q || chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         more_q  <= 1'b0;
         chain_q <= 1'b0;
         mask_q  <= '0;
         wb_req  <= 1'b0;
         wb_addr <= '0;
         wb_cnt  <= '0;
         head    <= '0;
      end else begin
         wb_req <= 1'b0;
         if (trigger) begin
            chain_q <= 1'b0;
            mask_q  <= eff_mask;
            more_q  <= clip;
            if (cnt_calc != '0) begin
               busy_q  <= 1'b1;
               wb_req  <= 1'b1;
               wb_addr <= base + (ADDR_W'(head) << DSH);
               wb_cnt  <= CNT_W'(cnt_calc);
            end
         end else if (busy_q) begin
            if (pend_min) begin
               mask_q <= flush_mask;
               more_q <= 1'b1;
            end
            if (wb_done) begin
               busy_q  <= 1'b0;
               head    <= (nh >= {1'b0, ring_len}) ? nh_wrap[IDX_W-1:0] : nh[IDX_W-1:0];
               chain_q <= more_q || pend_min;
               more_q  <= 1'b0;
            end
         end
         if (head_wr) head <= head_wdata;
      end
   end
endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache
   import drc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 12,
   parameter int CAP    = 8,
   parameter int DESC_W = 128,
   localparam int CAP_W      = $clog2(CAP),
   localparam int CNT_W      = CAP_W + 1,
   localparam int DESC_BYTES = DESC_W / 8,
   localparam int DSH        = $clog2(DESC_BYTES),
   localparam int LEN_W      = IDX_W + DSH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              cfg_err,
   output logic [IDX_W-1:0]  ring_head,
   output logic [IDX_W-1:0]  fetch_ptr,
   output logic [IDX_W:0]    avail_cnt,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_cnt,
   input  logic              rd_beat_valid,
   input  logic [DESC_W-1:0] rd_beat_data,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [CNT_W-1:0]  wb_cnt,
   input  logic [CAP_W-1:0]  wb_rd_idx,
   output logic [DESC_W-1:0] wb_rd_data,
   input  logic              wb_done,
   output logic              eng_valid,
   output logic [DESC_W-1:0] eng_desc,
   input  logic              eng_take,
   input  logic [DESC_W-1:0] eng_result,
   input  logic              flush_req,
   input  logic [IDX_W-1:0]  flush_mask
);
   initial begin : p_elab_chk
      assert (CAP >= 2 && (CAP & (CAP - 1)) == 0)
         else $fatal(1, "CAP must be a power of two of at least 2");
      assert (DESC_W >= 8 && (DESC_BYTES & (DESC_BYTES - 1)) == 0 && DESC_W % 8 == 0)
         else $fatal(1, "DESC_W must be a power-of-two number of bytes");
      assert (IDX_W >= CNT_W && ADDR_W >= LEN_W)
         else $fatal(1, "index or address width too small");
   end

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  ring_len, tail_q;
   logic [CNT_W-1:0]  n_used, n_unused, n_free, retire_n;
   logic              fetch_busy, wb_busy, retire, take;
   logic              area_wr, locked, legal_chg, err_q;
   logic [IDX_W:0]    ring_part;

   assign area_wr   = cfg_we && (cfg_sel != SEL_TAIL);
   assign locked    = (n_used != '0) || fetch_busy || wb_busy;
   assign legal_chg = area_wr && !locked;
   assign take      = eng_take && eng_valid && !legal_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         ring_len <= '0;
         tail_q   <= '0;
         err_q    <= 1'b0;
      end else begin
         if (cfg_we && cfg_sel == SEL_TAIL) tail_q <= cfg_wdata[IDX_W-1:0];
         if (legal_chg && cfg_sel == SEL_BASE) base_q <= cfg_wdata;
         if (legal_chg && cfg_sel == SEL_LEN) ring_len <= cfg_wdata[LEN_W-1:DSH];
         if (area_wr && locked) err_q <= 1'b1;
      end
   end
   assign cfg_err = err_q;

   drc_store #(.DESC_W(DESC_W), .CAP(CAP)) u_store (
      .clk, .rst_n,
      .clear      (legal_chg),
      .push       (rd_beat_valid && fetch_busy),
      .push_data  (rd_beat_data),
      .take       (take),
      .take_data  (eng_result),
      .retire     (retire),
      .retire_n   (retire_n),
      .peek_idx   (wb_rd_idx),
      .front_data (eng_desc),
      .peek_data  (wb_rd_data),
      .n_used     (n_used),
      .n_unused   (n_unused),
      .n_free     (n_free)
   );

   drc_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DSH(DSH)) u_fetch (
      .clk, .rst_n,
      .clear      (legal_chg),
      .hold       (legal_chg),
      .base       (base_q),
      .ring_len   (ring_len),
      .tail       (tail_q),
      .n_free     (n_free),
      .beat_valid (rd_beat_valid),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .rd_cnt     (rd_cnt),
      .busy       (fetch_busy),
      .cptr       (fetch_ptr)
   );

   drc_wback #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DSH(DSH)) u_wback (
      .clk, .rst_n,
      .head_wr    (legal_chg && cfg_sel == SEL_HEAD),
      .head_wdata (cfg_wdata[IDX_W-1:0]),
      .base       (base_q),
      .ring_len   (ring_len),
      .n_used     (n_used),
      .flush_req  (flush_req),
      .flush_mask (flush_mask),
      .wb_done    (wb_done),
      .wb_req     (wb_req),
      .wb_addr    (wb_addr),
      .wb_cnt     (wb_cnt),
      .busy       (wb_busy),
      .head       (ring_head),
      .retire     (retire),
      .retire_n   (retire_n)
   );

   assign eng_valid = n_unused != '0;
   assign ring_part = (fetch_ptr >= tail_q)
                    ? ({1'b0, ring_len} - {1'b0, fetch_ptr} + {1'b0, tail_q})
                    : ({1'b0, tail_q} - {1'b0, fetch_ptr});
   assign avail_cnt = ring_part + (IDX_W+1)'(n_unused);
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
   parameter int IDX_W = 12,
   parameter int CNT_W = 4,
   parameter int CAP   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic [CNT_W-1:0] rd_cnt,
   input logic [IDX_W-1:0] fetch_ptr,
   input logic [IDX_W-1:0] ring_len,
   input logic             wb_req,
   input logic [CNT_W-1:0] wb_cnt,
   input logic [IDX_W-1:0] ring_head,
   input logic [CNT_W-1:0] n_used,
   input logic [CNT_W-1:0] n_unused,
   input logic             cfg_err
);
   // R2: a read burst is nonempty and ends at or before the ring end
   a_r2_burst_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_cnt != '0) && (({1'b0, fetch_ptr} + (IDX_W+1)'(rd_cnt)) <= {1'b0, ring_len}));
   // R3: the store never holds more than its capacity
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ((n_used + n_unused) <= CNT_W'(CAP)));
   // R4: read requests never come back to back
   a_r4_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   // R6: a write burst is nonempty and ends at or before the ring end
   a_r6_wb_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> (wb_cnt != '0) && (({1'b0, ring_head} + (IDX_W+1)'(wb_cnt)) <= {1'b0, ring_len}));
   // R7: write requests never come back to back
   a_r7_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |=> !wb_req);
   // R11: the error flag is sticky
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
endmodule

bind desc_ring_cache drc_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W), .CAP(CAP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_cnt    (rd_cnt),
   .fetch_ptr (fetch_ptr),
   .ring_len  (ring_len),
   .wb_req    (wb_req),
   .wb_cnt    (wb_cnt),
   .ring_head (ring_head),
   .n_used    (n_used),
   .n_unused  (n_unused),
   .cfg_err   (cfg_err)
);

// File: tb/desc_ring_cache_tb.sv
module desc_ring_cache_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int IDX_W  = 12;
   localparam int CAP    = 4;
   localparam int DESC_W = 128;
   localparam int CAP_W  = $clog2(CAP);
   localparam int CNT_W  = CAP_W + 1;
   localparam logic [31:0] BASE = 32'h1000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [ADDR_W-1:0] cfg_wdata = 0;
   logic cfg_err; logic [IDX_W-1:0] ring_head, fetch_ptr; logic [IDX_W:0] avail_cnt;
   logic rd_req; logic [ADDR_W-1:0] rd_addr; logic [CNT_W-1:0] rd_cnt;
   logic rd_beat_valid = 0; logic [DESC_W-1:0] rd_beat_data = 0;
   logic wb_req; logic [ADDR_W-1:0] wb_addr; logic [CNT_W-1:0] wb_cnt;
   logic [CAP_W-1:0] wb_rd_idx = 0; logic [DESC_W-1:0] wb_rd_data; logic wb_done = 0;
   logic eng_valid; logic [DESC_W-1:0] eng_desc; logic eng_take = 0;
   logic [DESC_W-1:0] eng_result = 0;
   logic flush_req = 0; logic [IDX_W-1:0] flush_mask = 0;

   int checks = 0, errors = 0;
   int rd_seen = 0, rd_used = 0, wb_seen = 0, wb_used = 0;
   logic [ADDR_W-1:0] rd_a, wb_a; logic [CNT_W-1:0] rd_c, wb_c;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_ring_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP), .DESC_W(DESC_W)) u_dut (.*);

   // request monitor: registered pulses sampled at the rising edge
   always @(posedge clk) if (rst_n) begin
      if (rd_req) begin rd_seen++; rd_a = rd_addr; rd_c = rd_cnt; end
      if (wb_req) begin wb_seen++; wb_a = wb_addr; wb_c = wb_cnt; end
   end

   function automatic logic [DESC_W-1:0] mk(int idx);
      return {96'h0, 32'hD000_0000 + 32'(idx)};
   endfunction
   function automatic logic [DESC_W-1:0] res(int idx);
      return {96'h0, 32'hE000_0000 + 32'(idx)};
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(logic [1:0] sel, logic [31:0] val);
      @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic flush(logic [IDX_W-1:0] m);
      @(negedge clk); flush_req = 1; flush_mask = m;
      @(negedge clk); flush_req = 0;
   endtask

   task automatic take_n(int n, int first, string tag);
      for (int k = 0; k < n; k++) begin
         chk({tag, " eng_valid"}, eng_valid, 1);
         chk({tag, " eng_desc order"}, eng_desc[63:0], mk(first + k));
         eng_take = 1; eng_result = res(first + k);
         @(negedge clk);
      end
      eng_take = 0;
   endtask

   task automatic serve_fetch(logic [31:0] exp_a, int exp_c, int first, int gap, string tag);
      for (int i = 0; i < 60 && rd_seen == rd_used; i++) @(negedge clk);
      chk({tag, " read issued"}, rd_seen, rd_used + 1);
      rd_used = rd_seen;
      chk({tag, " read addr"}, rd_a, exp_a);
      chk({tag, " read count"}, rd_c, exp_c);
      for (int i = 0; i < gap; i++) @(negedge clk);
      if (gap > 0) chk({tag, " R4 no second read"}, rd_seen, rd_used);
      for (int k = 0; k < exp_c; k++) begin
         rd_beat_valid = 1; rd_beat_data = mk(first + k);
         @(negedge clk);
      end
      rd_beat_valid = 0;
   endtask

   task automatic serve_wb(logic [31:0] exp_a, int exp_c, int first, bit mid, logic [IDX_W-1:0] mmask, string tag);
      for (int i = 0; i < 60 && wb_seen == wb_used; i++) @(negedge clk);
      chk({tag, " write issued"}, wb_seen, wb_used + 1);
      wb_used = wb_seen;
      chk({tag, " write addr"}, wb_a, exp_a);
      chk({tag, " write count"}, wb_c, exp_c);
      for (int k = 0; k < exp_c; k++) begin
         wb_rd_idx = CAP_W'(k); #1;
         chk({tag, " R12 write data"}, wb_rd_data[63:0], res(first + k));
      end
      if (mid) flush(mmask);
      @(negedge clk); wb_done = 1;
      @(negedge clk); wb_done = 0;
   endtask

   task automatic quiet(int n, string tag);
      int r0 = rd_seen, w0 = wb_seen;
      repeat (n) @(negedge clk);
      chk({tag, " no read"}, rd_seen, r0);
      chk({tag, " no write"}, wb_seen, w0);
   endtask

   task automatic t_reset();
      chk("R1 rd_req", rd_req, 0);
      chk("R1 wb_req", wb_req, 0);
      chk("R1 cfg_err", cfg_err, 0);
      chk("R1 head", ring_head, 0);
      chk("R1 fetch_ptr", fetch_ptr, 0);
      chk("R1 eng_valid", eng_valid, 0);
      cfg_write(2'd0, BASE);
      cfg_write(2'd1, 32'd128);
      chk("R1 ring size from length (avail through ring end)", avail_cnt, 8);
   endtask

   task automatic t_first_fetch();
      cfg_write(2'd3, 32'd5);
      serve_fetch(BASE, 4, 0, 0, "R2 R3 R5 first burst");
      quiet(4, "R3 store full");
      chk("R4 pointer advanced", fetch_ptr, 4);
      chk("R9 avail", avail_cnt, 5);
   endtask

   task automatic t_simple_wb();
      take_n(2, 0, "R12 take");
      flush(0);
      serve_wb(BASE, 2, 0, 1, 12'd1, "R5 R6 plain wb, R7 larger mask");
      chk("R8 head advanced", ring_head, 2);
      serve_fetch(BASE + 32'h40, 1, 4, 3, "R3 R4 capped refill");
      quiet(4, "R7 larger mask queued nothing");
      chk("R4 pointer", fetch_ptr, 5);
      chk("R9 avail pointer at tail", avail_cnt, 11);
   endtask

   task automatic t_align_chain();
      take_n(3, 2, "R12 take");
      flush(1);
      serve_wb(BASE + 32'h20, 2, 2, 1, 12'd0, "R6 aligned wb");
      serve_wb(BASE + 32'h40, 1, 4, 0, 12'd0, "R7 R8 chained wb");
      chk("R8 head after chain", ring_head, 5);
   endtask

   task automatic t_wrap();
      cfg_write(2'd3, 32'd2);
      serve_fetch(BASE + 32'h50, 3, 5, 0, "R2 burst up to ring end");
      serve_fetch(BASE, 1, 0, 0, "R4 pointer wrapped to 0");
      take_n(3, 5, "R12 take before wrap");
      take_n(1, 0, "R12 take after wrap");
      flush(0);
      serve_wb(BASE + 32'h50, 3, 5, 0, 12'd0, "R6 clipped wb");
      chk("R8 head wrapped", ring_head, 0);
      serve_wb(BASE, 1, 0, 0, 12'd0, "R6 R8 follow-up after clip");
      serve_fetch(BASE + 32'h10, 1, 1, 0, "R2 refill after wrap");
      chk("R8 head", ring_head, 1);
   endtask

   task automatic t_cfg();
      take_n(1, 1, "R12 take");
      cfg_write(2'd2, 32'd3);
      chk("R11 error set", cfg_err, 1);
      chk("R11 head kept", ring_head, 1);
      cfg_write(2'd0, 32'h8000);
      flush(0);
      serve_wb(BASE + 32'h10, 1, 1, 0, 12'd0, "R11 base kept");
      chk("R8 head", ring_head, 2);
      cfg_write(2'd2, 32'd6);
      chk("R10 head written", ring_head, 6);
      chk("R10 pointer reset", fetch_ptr, 0);
      chk("R10 store emptied", eng_valid, 0);
      chk("R9 R10 avail", avail_cnt, 2);
      chk("R11 error sticky", cfg_err, 1);
      serve_fetch(BASE, 2, 0, 0, "R10 refetch from ring start");
      chk("R12 first after reset", eng_desc[63:0], mk(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_first_fetch();
      t_simple_wb();
      t_align_chain();
      t_wrap();
      t_cfg();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule